// File: doc/BRIEF.md
# Masked-Compare Repetitive Interrupt Timer

The block is a free-running up-counter that raises a periodic interrupt. Software programs a compare value and a bit mask. Each cycle the counter is checked against the compare value, and bit positions selected by the mask are ignored. When the counter matches, the block sets a sticky interrupt flag. If software has enabled it, the block also restarts the counter from zero, which gives a fixed interrupt period.

Counting stops in two cases. The first is when software clears the enable bit. The second is when an external debug-halt line is high and the break-enable bit is set. While counting is stopped, no match can fire. All four registers (compare, mask, control, counter) are reached through a single-cycle synchronous write port and a combinational read port. Software can overwrite the counter at any time.

Top module: `rpt_irq_timer`

## Requirements
- R1: After a synchronous active-low reset, the registers read as follows: counter 0, compare all ones, mask 0, control 0b0110 (timer enable and break enable set, clear-on-match and flag clear). `irq` is low.
- R2: The read and write address map is 0 compare, 1 mask, 2 control, 3 counter. Control bit positions are: bit 0 flag, bit 1 break enable, bit 2 timer enable, bit 3 clear-on-match; the upper control bits read as zero. A value written reads back unchanged in the next cycle.
- R3: While counting runs, the counter adds one at each clock edge and wraps from all ones to zero.
- R4: A match exists when `((counter ^ compare) & ~mask) == 0`. A match while counting runs sets the flag at that edge, and `irq` always equals the flag.
- R5: With timer enable at 0, the counter holds its value.
- R6: When break enable is 1 and `dbg_halt` is high, the counter holds. When break enable is 0, `dbg_halt` has no effect.
- R7: While counting is stopped, no match sets the flag, even when the compare condition is true.
- R8: Writing control with bit 0 at 1 clears the flag. Writing bit 0 at 0 leaves the flag unchanged.
- R9: If a match and a flag-clear write happen at the same edge, the flag stays set.
- R10: With clear-on-match set, a match loads the counter with zero instead of incrementing it.
- R11: A counter write loads the written value at that edge and takes priority over counting and clear-on-match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 2 | Register address for read and write |
| bus_wdata | input | CNT_W | Write data |
| bus_rdata | output | CNT_W | Combinational read data for `bus_addr` |
| dbg_halt | input | 1 | Debug-halt request |
| irq | output | 1 | Interrupt, equal to the sticky flag |

## Verification
The bench uses an 8-bit counter and sweeps compare values against several masks. For each pair it checks that the first interrupt arrives after exactly `(compare & ~mask) + 1` edges. A comparator that inverts the mask sense, or that leaves out the mask, shows up as a wrong edge count. A counter that fails to wrap shows up at the all-ones corner. Other corners the bench exercises:
- It collides a flag-clear write with a live match. A design that lets the clear win drops `irq`.
- It holds the compare condition true while counting is stopped. A design that does not gate match with the run state raises `irq` while stopped.
- It checks the counter value after a match with clear-on-match set. A design that clears a cycle late, or that keeps incrementing, reads back a nonzero value.

// File: rtl/rit_pkg.sv
// Shared definitions for the repetitive interrupt timer.
// Assumes a 2-bit register address and a 4-bit control field.
package rit_pkg;

    typedef enum logic [1:0] {
        REG_CMP  = 2'd0,
        REG_MASK = 2'd1,
        REG_CTRL = 2'd2,
        REG_CNT  = 2'd3
    } rit_reg_e;

    localparam int CTRL_W        = 4;
    localparam int CTRL_FLAG_BIT = 0;
    localparam int CTRL_BRK_BIT  = 1;
    localparam int CTRL_EN_BIT   = 2;
    localparam int CTRL_CLRM_BIT = 3;

endpackage

// File: rtl/rit_match.sv
// Masked comparator and run qualification.
// Produces the run state and a one-cycle match event. The event is only
// raised while counting runs. Purely combinational.
module rit_match #(
    parameter int CNT_W = 32
) (
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] cmp,
    input  logic [CNT_W-1:0] mask,
    input  logic             en,
    input  logic             brk_en,
    input  logic             dbg_halt,
    output logic             run,
    output logic             match_evt
);

    logic [CNT_W-1:0] bit_miss;

    // Per-bit mismatch, forced to zero where the mask marks a don't-care.
    for (genvar i = 0; i < CNT_W; i++) begin : g_bit
        assign bit_miss[i] = (cnt[i] ^ cmp[i]) & ~mask[i];
    end

    // Counting runs unless software disabled it or break halts it.
    always_comb run = en & ~(brk_en & dbg_halt);

    // A match event needs a running counter and no mismatching bit.
    always_comb match_evt = run & ~(|bit_miss);

endmodule

// File: rtl/rit_counter.sv
// Free-running counter with software load and optional clear on match.
// Assumes load, run and match_evt are valid before the clock edge.
module rit_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             match_evt,
    input  logic             clr_on_match,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] cnt
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    // Counter update: load first, then clear on match, then increment.
    always_ff @(posedge clk) begin
        if (!rst_n)                         cnt <= '0;
        else if (load)                      cnt <= load_val;
        else if (match_evt && clr_on_match) cnt <= '0;
        else if (run)                       cnt <= cnt + ONE;
    end

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        run && !load && !(match_evt && clr_on_match) |=> cnt == CNT_W'($past(cnt) + ONE)); // R3
    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !run && !load |=> $stable(cnt)); // R5
    AST_CNT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> cnt == $past(load_val)); // R11
    AST_CNT_CLR_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        match_evt && clr_on_match && !load |=> cnt == '0); // R10

endmodule

// File: rtl/rit_regs.sv
// Compare, mask and control registers, plus the sticky interrupt flag.
// Assumes one write per cycle, with the write strobes already decoded.
// A hardware set of the flag has priority over a software clear.
module rit_regs #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_cmp,
    input  logic             wr_mask,
    input  logic             wr_ctrl,
    input  logic [CNT_W-1:0] wdata,
    input  logic             match_evt,
    output logic [CNT_W-1:0] cmp_q,
    output logic [CNT_W-1:0] mask_q,
    output logic             en_q,
    output logic             brk_q,
    output logic             clrm_q,
    output logic             flag_q
);
    import rit_pkg::*;

    logic flag_clr;

    // Compare register, resets to all ones.
    always_ff @(posedge clk) begin
        if (!rst_n)      cmp_q <= '1;
        else if (wr_cmp) cmp_q <= wdata;
    end

    // Mask register, resets to no don't-care bits.
    always_ff @(posedge clk) begin
        if (!rst_n)       mask_q <= '0;
        else if (wr_mask) mask_q <= wdata;
    end

    // Control bits; enable and break enable come out of reset set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= 1'b1;
            brk_q  <= 1'b1;
            clrm_q <= 1'b0;
        end else if (wr_ctrl) begin
            en_q   <= wdata[CTRL_EN_BIT];
            brk_q  <= wdata[CTRL_BRK_BIT];
            clrm_q <= wdata[CTRL_CLRM_BIT];
        end
    end

    // Clear request: a control write with a one in the flag position.
    always_comb flag_clr = wr_ctrl & wdata[CTRL_FLAG_BIT];

    // Sticky flag: a match sets it, a clear request clears it, a set wins.
    always_ff @(posedge clk) begin
        if (!rst_n)         flag_q <= 1'b0;
        else if (match_evt) flag_q <= 1'b1;
        else if (flag_clr)  flag_q <= 1'b0;
    end

    AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
        match_evt |=> flag_q); // R4
    AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        flag_clr && !match_evt |=> !flag_q); // R8
    AST_FLAG_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        !flag_clr && !match_evt |=> flag_q == $past(flag_q)); // R7
    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        flag_clr && match_evt |=> flag_q); // R9

endmodule

// File: rtl/rpt_irq_timer.sv
// Repetitive interrupt timer, top level.
// Decodes the register port, combines the counter, the comparator and the
// registers, and returns read data combinationally. Assumes CNT_W >= 4.
module rpt_irq_timer #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_wr,
    input  logic [1:0]       bus_addr,
    input  logic [CNT_W-1:0] bus_wdata,
    output logic [CNT_W-1:0] bus_rdata,
    input  logic             dbg_halt,
    output logic             irq
);
    import rit_pkg::*;

    rit_reg_e         sel;
    logic             wr_cmp, wr_mask, wr_ctrl, wr_cnt;
    logic [CNT_W-1:0] cnt, cmp_q, mask_q;
    logic             en_q, brk_q, clrm_q, flag_q;
    logic             run, match_evt;
    logic [CTRL_W-1:0] ctrl_view;

    // Address decode into one write strobe per register.
    always_comb begin
        sel     = rit_reg_e'(bus_addr);
        wr_cmp  = bus_wr && (sel == REG_CMP);
        wr_mask = bus_wr && (sel == REG_MASK);
        wr_ctrl = bus_wr && (sel == REG_CTRL);
        wr_cnt  = bus_wr && (sel == REG_CNT);
    end

    rit_regs #(.CNT_W(CNT_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_cmp    (wr_cmp),
        .wr_mask   (wr_mask),
        .wr_ctrl   (wr_ctrl),
        .wdata     (bus_wdata),
        .match_evt (match_evt),
        .cmp_q     (cmp_q),
        .mask_q    (mask_q),
        .en_q      (en_q),
        .brk_q     (brk_q),
        .clrm_q    (clrm_q),
        .flag_q    (flag_q)
    );

    rit_match #(.CNT_W(CNT_W)) u_match (
        .cnt       (cnt),
        .cmp       (cmp_q),
        .mask      (mask_q),
        .en        (en_q),
        .brk_en    (brk_q),
        .dbg_halt  (dbg_halt),
        .run       (run),
        .match_evt (match_evt)
    );

    rit_counter #(.CNT_W(CNT_W)) u_counter (
        .clk          (clk),
        .rst_n        (rst_n),
        .run          (run),
        .match_evt    (match_evt),
        .clr_on_match (clrm_q),
        .load         (wr_cnt),
        .load_val     (bus_wdata),
        .cnt          (cnt)
    );

    // Control view in its bit positions.
    always_comb begin
        ctrl_view                = '0;
        ctrl_view[CTRL_FLAG_BIT] = flag_q;
        ctrl_view[CTRL_BRK_BIT]  = brk_q;
        ctrl_view[CTRL_EN_BIT]   = en_q;
        ctrl_view[CTRL_CLRM_BIT] = clrm_q;
    end

    // Read mux, zero-extending the control view.
    always_comb begin
        case (sel)
            REG_CMP:  bus_rdata = cmp_q;
            REG_MASK: bus_rdata = mask_q;
            REG_CTRL: bus_rdata = CNT_W'(ctrl_view);
            default:  bus_rdata = cnt;
        endcase
    end

    // Interrupt output mirrors the sticky flag.
    always_comb irq = flag_q;

    AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        brk_q && dbg_halt && !wr_cnt |=> $stable(cnt)); // R6
    AST_NO_EVT_PAUSED: assert property (@(posedge clk) disable iff (!rst_n)
        !run && !irq && !wr_ctrl |=> !irq); // R7

endmodule

// File: tb/rpt_irq_timer_tb.sv
module rpt_irq_timer_tb;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         bus_wr = 1'b0;
    logic [1:0]   bus_addr = 2'd0;
    logic [W-1:0] bus_wdata = '0;
    logic [W-1:0] bus_rdata;
    logic         dbg_halt = 1'b0;
    logic         irq;

    int n_chk = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    rpt_irq_timer #(.CNT_W(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .dbg_halt(dbg_halt), .irq(irq)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [W-1:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output int d);
        bus_addr = a;
        #1;
        d = int'(bus_rdata);
    endtask

    // Stop, clear the flag, zero the counter, program compare and mask.
    task automatic setup(input logic [W-1:0] c, input logic [W-1:0] m);
        wr(2'd2, 8'h00);
        wr(2'd2, 8'h01);
        wr(2'd3, 8'h00);
        wr(2'd0, c);
        wr(2'd1, m);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int v, n, c0;
        int masks [4] = '{8'h00, 8'h0F, 8'hF0, 8'h55};
        // R1 reset values, read while reset is held
        repeat (2) @(negedge clk);
        rd(2'd0, v); check("R1 cmp", v, 8'hFF);
        rd(2'd1, v); check("R1 mask", v, 0);
        rd(2'd2, v); check("R1 ctrl", v, 6);
        rd(2'd3, v); check("R1 cnt", v, 0);
        check("R1 irq", int'(irq), 0);
        rst_n = 1'b1;

        // R2 readback
        wr(2'd2, 8'h0A);
        rd(2'd2, v); check("R2 ctrl", v, 8'h0A);
        wr(2'd0, 8'h3C); rd(2'd0, v); check("R2 cmp", v, 8'h3C);
        wr(2'd1, 8'hA5); rd(2'd1, v); check("R2 mask", v, 8'hA5);

        // R3/R4 sweep: first match at compare & ~mask
        for (int mi = 0; mi < 4; mi++) begin
            for (int c = 0; c < 256; c += 17) begin
                int exp_v;
                exp_v = c & ~masks[mi] & 8'hFF;
                setup(8'(c), 8'(masks[mi]));
                wr(2'd2, 8'h04);
                n = 0;
                while (!irq && n < 300) begin
                    @(negedge clk);
                    n++;
                end
                check("R4 match edge count", n, exp_v + 1);
                rd(2'd3, v); check("R3 counter at match", v, (exp_v + 1) & 8'hFF);
            end
        end

        // R10 clear on match
        setup(8'd5, 8'h00);
        wr(2'd2, 8'h0C);
        n = 0;
        while (!irq && n < 300) begin @(negedge clk); n++; end
        check("R10 edges", n, 6);
        rd(2'd3, v); check("R10 cnt zero", v, 0);
        @(negedge clk); rd(2'd3, v); check("R10 cnt restarts", v, 1);

        // R9 set wins, R8 clear, R7 no event while disabled
        setup(8'h00, 8'hFF);
        wr(2'd2, 8'h04);
        @(negedge clk); check("R4 irq all-mask", int'(irq), 1);
        wr(2'd2, 8'h01); check("R9 set beats clear", int'(irq), 1);
        wr(2'd2, 8'h01); check("R8 clear", int'(irq), 0);
        repeat (3) @(negedge clk);
        check("R7 no event when disabled", int'(irq), 0);
        rd(2'd3, c0);
        rd(2'd3, v); check("R5 disabled holds", v, c0);
        wr(2'd2, 8'h04);
        wr(2'd2, 8'h00);
        check("R4 flag set", int'(irq), 1);
        wr(2'd2, 8'h00); check("R8 write zero keeps flag", int'(irq), 1);

        // R6 debug halt with break enable
        setup(8'hFF, 8'h00);
        wr(2'd3, 8'h10);
        dbg_halt = 1'b1;
        wr(2'd2, 8'h06);
        repeat (4) @(negedge clk);
        rd(2'd3, v); check("R6 halted holds", v, 8'h10);
        wr(2'd1, 8'hFF);
        wr(2'd2, 8'h07);
        repeat (4) @(negedge clk);
        check("R7 no event while halted", int'(irq), 0);
        dbg_halt = 1'b0;
        @(negedge clk);
        check("R7 event after release", int'(irq), 1);
        wr(2'd1, 8'h00);
        rd(2'd3, c0);
        repeat (3) @(negedge clk);
        rd(2'd3, v); check("R3 counts after release", v, (c0 + 3) & 8'hFF);
        dbg_halt = 1'b1;
        wr(2'd2, 8'h04);
        rd(2'd3, c0);
        repeat (4) @(negedge clk);
        rd(2'd3, v); check("R6 halt ignored without break", v, (c0 + 4) & 8'hFF);
        dbg_halt = 1'b0;

        // R11 counter load while running
        wr(2'd3, 8'h80);
        rd(2'd3, v); check("R11 load", v, 8'h80);
        @(negedge clk); rd(2'd3, v); check("R11 counts from load", v, 8'h81);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule